// File: doc/BRIEF.md
# Pipelined Address Bus Cycle Controller

This block is the master side of a parallel memory and I/O bus. It takes internal transfer requests, each an address plus a few cycle-definition bits, and turns them into bus cycles. A cycle starts with a one-clock, active-low address strobe while the address and definition are driven. It ends when the slave pulls the active-low ready input low. Only one request is held at a time. A request is offered with `reqValid` and taken when `reqAccept` is high in the same clock.

The slave can ask for the next address early by pulling the active-low next-address input low during a wait state. The controller then overlaps the address phase of the next cycle with the data phase of the current one. If a request is waiting, the next address goes out at once and the bus moves into the pipelined second state. If no request is waiting, the bus moves into the idle second state. It stays there until a request shows up or the current cycle ends. The controller looks only one cycle ahead.

The current bus state is exposed as a code: 0 idle, 1 first state, 2 second state, 3 pipelined second state, 4 idle second state. Reset is synchronous and active-low.

Top module: `pipe_addr_bus_ctrl`

## Requirements
- R1: While `rstN` is low at a clock edge, the next state is: `busPhase` 0 (idle), `adsN` 1, `busAddr` and `busDef` 0. `reqAccept` is 0 whenever `rstN` is low.
- R2: In idle (code 0), `reqAccept` equals `reqValid` in the same clock. After an accept, the next clock shows code 1 with `adsN` low and the accepted address and definition on `busAddr` and `busDef`. With no request, the bus stays in code 0.
- R3: `adsN` is low for exactly one clock, and only in the clock right after an accepting edge. State 1 is always followed by state 2. `readyN`, `nextAddrN` and `reqValid` have no effect in state 1, and `reqAccept` is 0 there.
- R4: `busAddr` and `busDef` change only at an accepting edge, which is a clock where `adsN` goes low. Every issued address stays unchanged for at least two clocks.
- R5: In state 2 with `readyN` low, ready takes priority over next-address. If `reqValid` is high, the request is accepted and the next state is 1. Otherwise the next state is 0.
- R6: In state 2 with `readyN` high, `nextAddrN` low and `reqValid` high, the request is accepted and the next state is 3.
- R7: In state 2 with `readyN` high, `nextAddrN` low and `reqValid` low, the next state is 4. No strobe is issued and `reqAccept` is 0.
- R8: In state 4, if `readyN` is high and `reqValid` is high, the request is accepted and the next state is 3. If `readyN` is low, the next state is 1 when a request is accepted and 0 otherwise. If both are high, the bus stays in state 4.
- R9: In state 3, `reqAccept` is 0 and `nextAddrN` is ignored. With `readyN` low, the next state is 2 with the address unchanged. Otherwise the bus stays in state 3.
- R10: In state 2 with both `readyN` and `nextAddrN` high, the bus stays in state 2 and `reqAccept` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | An internal request is offered |
| reqAddr | input | ADDR_W (24) | Address of the offered request |
| reqDef | input | DEF_W (3) | Cycle-definition bits of the offered request |
| reqAccept | output | 1 | The request is taken in this clock |
| nextAddrN | input | 1 | Slave asks for the next address, active low |
| readyN | input | 1 | Slave ends the current cycle, active low |
| busAddr | output | ADDR_W (24) | Address outputs |
| busDef | output | DEF_W (3) | Cycle-definition outputs |
| adsN | output | 1 | Address strobe, active low, one clock |
| busPhase | output | 3 | Bus state code: 0 idle, 1 first, 2 second, 3 pipelined second, 4 idle second |

## Verification
The assertions are checked on every cycle. They cover the one-clock strobe width, the rule that the address moves only together with a strobe, and the fixed state steps. Those steps are first to second state, wait-state next-address into state 3 or 4, no acceptance in state 3, and ready ending state 3 back into state 2 with the address held. Only the bench's scenarios can show the full picture, because they compare every output against an independent model. That includes the ready-over-next-address priority, requests arriving late in state 4, and ready arriving in state 4 with or without a request. The scenarios also cover back-to-back pipelined cycles, the two-clock address hold measured at the pins, and a reset in the middle of traffic.

// File: rtl/pab_pkg.sv
package pab_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T2P  = 3'd3,
    PH_T2I  = 3'd4
  } busPhase_e;

  // Strobes from the sequencer to the address/definition datapath
  typedef struct packed {
    logic load;      // capture the offered request and pulse the strobe
    logic pipelined; // the capture overlaps a still-open cycle
  } dpStrobe_t;

endpackage

// File: rtl/pab_ctrl.sv
module pab_ctrl
  import pab_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       nextAddrN,
  input  logic       readyN,
  output busPhase_e  phase,
  output logic       reqAccept,
  output dpStrobe_t  strobe
);

  busPhase_e stateQ, stateD;
  logic      accD;
  logic      pipeD;

  always_comb begin
    stateD = stateQ;
    accD   = 1'b0;
    pipeD  = 1'b0;
    unique case (stateQ)
      PH_IDLE: begin
        if (reqValid) begin
          accD   = 1'b1;
          stateD = PH_T1;
        end
      end
      PH_T1: begin
        stateD = PH_T2;
      end
      PH_T2: begin
        if (!readyN) begin
          if (reqValid) begin
            accD   = 1'b1;
            stateD = PH_T1;
          end else begin
            stateD = PH_IDLE;
          end
        end else if (!nextAddrN) begin
          if (reqValid) begin
            accD   = 1'b1;
            pipeD  = 1'b1;
            stateD = PH_T2P;
          end else begin
            stateD = PH_T2I;
          end
        end
      end
      PH_T2P: begin
        if (!readyN) stateD = PH_T2;
      end
      PH_T2I: begin
        if (!readyN) begin
          if (reqValid) begin
            accD   = 1'b1;
            stateD = PH_T1;
          end else begin
            stateD = PH_IDLE;
          end
        end else if (reqValid) begin
          accD   = 1'b1;
          pipeD  = 1'b1;
          stateD = PH_T2P;
        end
      end
      default: stateD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= PH_IDLE;
    else       stateQ <= stateD;
  end

  assign phase            = stateQ;
  assign reqAccept        = accD & rstN;
  assign strobe.load      = accD & rstN;
  assign strobe.pipelined = pipeD & rstN;

  // Becomes set once a reset edge has been seen; guards checks looking back
  logic armed;
  always_ff @(posedge clk) begin
    armed <= armed | ~rstN;
  end

  a_r2_accept_to_t1: assert property (@(posedge clk) disable iff (!rstN)
    armed && phase == PH_IDLE && reqAccept |=> phase == PH_T1);

  a_r3_first_to_second: assert property (@(posedge clk) disable iff (!rstN)
    armed && phase == PH_T1 |=> phase == PH_T2);

  a_r3_no_accept_first: assert property (@(posedge clk) disable iff (!rstN)
    armed && phase == PH_T1 |-> !reqAccept);

  a_r5_ready_closes: assert property (@(posedge clk) disable iff (!rstN)
    armed && phase == PH_T2 && !readyN |=> (phase == PH_IDLE || phase == PH_T1));

  a_r6_early_issue: assert property (@(posedge clk) disable iff (!rstN)
    armed && phase == PH_T2 && readyN && !nextAddrN && reqValid |=> phase == PH_T2P);

  a_r7_early_empty: assert property (@(posedge clk) disable iff (!rstN)
    armed && phase == PH_T2 && readyN && !nextAddrN && !reqValid |=> phase == PH_T2I);

  a_r9_one_ahead: assert property (@(posedge clk) disable iff (!rstN)
    armed && phase == PH_T2P |-> !reqAccept);

  a_r9_promote: assert property (@(posedge clk) disable iff (!rstN)
    armed && phase == PH_T2P && !readyN |=> phase == PH_T2);

  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    armed && phase == PH_T2 && readyN && nextAddrN |=> phase == PH_T2);

endmodule

// File: rtl/pab_datapath.sv
module pab_datapath
  import pab_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DEF_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DEF_W-1:0]  reqDef,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DEF_W-1:0]  busDef,
  output logic              adsN
);

  localparam int CYC_W = ADDR_W + DEF_W;

  logic [CYC_W-1:0] cycQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycQ <= '0;
      adsN <= 1'b1;
    end else begin
      adsN <= ~strobe.load;
      if (strobe.load) cycQ <= {reqAddr, reqDef};
    end
  end

  assign busAddr = cycQ[CYC_W-1:DEF_W];
  assign busDef  = cycQ[DEF_W-1:0];

  // Two-stage arm so that $past only reaches values set after a reset edge
  logic armedA, armedB;
  always_ff @(posedge clk) begin
    armedA <= armedA | ~rstN;
    armedB <= armedA;
  end

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    armedA && !adsN |=> adsN);

  a_r4_moves_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    armedB && !$stable({busAddr, busDef}) |-> !adsN);

  a_r4_hold_two: assert property (@(posedge clk) disable iff (!rstN)
    armedA && !adsN |=> $stable({busAddr, busDef}));

  a_r4_pipe_strobe: assert property (@(posedge clk) disable iff (!rstN)
    armedA && strobe.pipelined |-> strobe.load);

endmodule

// File: rtl/pipe_addr_bus_ctrl.sv
module pipe_addr_bus_ctrl
  import pab_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DEF_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DEF_W-1:0]  reqDef,
  output logic              reqAccept,
  input  logic              nextAddrN,
  input  logic              readyN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DEF_W-1:0]  busDef,
  output logic              adsN,
  output logic [2:0]        busPhase
);

  busPhase_e  phase;
  dpStrobe_t  strobe;

  pab_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .nextAddrN (nextAddrN),
    .readyN    (readyN),
    .phase     (phase),
    .reqAccept (reqAccept),
    .strobe    (strobe)
  );

  pab_datapath #(
    .ADDR_W (ADDR_W),
    .DEF_W  (DEF_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqDef  (reqDef),
    .busAddr (busAddr),
    .busDef  (busDef),
    .adsN    (adsN)
  );

  assign busPhase = phase;

endmodule

// File: tb/test_pipe_addr_bus_ctrl.sv
`timescale 1ns/1ps
module test_pipe_addr_bus_ctrl;

  localparam int AW = 24;
  localparam int DW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqDef = '0;
  logic          reqAccept;
  logic          nextAddrN = 1'b1;
  logic          readyN = 1'b1;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busDef;
  logic          adsN;
  logic [2:0]    busPhase;

  always #2.5 clk = ~clk;

  pipe_addr_bus_ctrl #(.ADDR_W(AW), .DEF_W(DW)) i_pipe_addr_bus_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqDef(reqDef), .reqAccept(reqAccept), .nextAddrN(nextAddrN),
    .readyN(readyN), .busAddr(busAddr), .busDef(busDef), .adsN(adsN),
    .busPhase(busPhase)
  );

  int checks = 0;
  int errors = 0;

  // Independent model state (codes from R2..R10)
  int            mPh = 0;
  logic          mAds = 1'b1;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mDef = '0;
  string         mRule = "R1";
  int            holdCnt = 100;
  logic [AW-1:0] prevAddr = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit expAccept(input int ph, input logic v, input logic na, input logic rd);
    case (ph)
      0: return v;
      2: return v && (!rd || !na);
      4: return v;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string acceptTag(input int ph);
    case (ph)
      0: return "R2";
      1: return "R3";
      2: return "R6";
      3: return "R9";
      default: return "R8";
    endcase
  endfunction

  function automatic int nextPh(input int ph, input logic v, input logic na, input logic rd);
    case (ph)
      0: return v ? 1 : 0;
      1: return 2;
      2: if (!rd) return v ? 1 : 0;
         else if (!na) return v ? 3 : 4;
         else return 2;
      3: return rd ? 3 : 2;
      default: if (!rd) return v ? 1 : 0;
               else return v ? 3 : 4;
    endcase
  endfunction

  function automatic string ruleOf(input int ph, input logic na, input logic rd);
    case (ph)
      0: return "R2";
      1: return "R3";
      2: if (!rd) return "R5";
         else if (!na) return "R6";
         else return "R10";
      3: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic compareAll();
    bit ea;
    ea = expAccept(mPh, reqValid, nextAddrN, readyN);
    check(reqAccept == ea, acceptTag(mPh), "reqAccept", reqAccept, ea);
    check(busPhase == mPh[2:0], mRule, "busPhase", busPhase, mPh);
    check(adsN == mAds, "R3", "adsN", adsN, mAds);
    check(busAddr == mAddr, "R4", "busAddr", busAddr, mAddr);
    check(busDef == mDef, "R4", "busDef", busDef, mDef);
    if (busAddr != prevAddr) begin
      check(holdCnt >= 2, "R4", "address hold clocks", holdCnt, 2);
      holdCnt = 1;
    end else begin
      holdCnt++;
    end
    prevAddr = busAddr;
  endtask

  task automatic drive(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic na, input logic rd);
    bit acc;
    @(negedge clk);
    reqValid = v; reqAddr = a; reqDef = d; nextAddrN = na; readyN = rd;
    #1;
    compareAll();
    acc   = expAccept(mPh, v, na, rd);
    mRule = ruleOf(mPh, na, rd);
    mPh   = nextPh(mPh, v, na, rd);
    mAds  = ~acc;
    if (acc) begin
      mAddr = a;
      mDef  = d;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqValid = 1'b1; reqAddr = 24'hABCDEF; reqDef = 3'd7;
    nextAddrN = 1'b0; readyN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    check(busPhase == 3'd0, "R1", "reset busPhase", busPhase, 0);
    check(adsN == 1'b1, "R1", "reset adsN", adsN, 1);
    check(busAddr == '0, "R1", "reset busAddr", busAddr, 0);
    check(busDef == '0, "R1", "reset busDef", busDef, 0);
    check(reqAccept == 1'b0, "R1", "reset reqAccept", reqAccept, 0);
    reqValid = 1'b0; nextAddrN = 1'b1; readyN = 1'b1; rstN = 1'b1;
    mPh = 0; mAds = 1'b1; mAddr = '0; mDef = '0; mRule = "R1";
    holdCnt = 100; prevAddr = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd1234);
    doReset();
    // R2: idle accept, R3: first state ignores inputs
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b1);
    drive(1'b1, 24'h000100, 3'd2, 1'b1, 1'b1);
    drive(1'b1, 24'h000200, 3'd1, 1'b0, 1'b0);
    // R7: next-address with no request -> idle second state
    drive(1'b0, 24'h0, 3'd0, 1'b0, 1'b1);
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b1);
    // R8: late request in idle second state -> pipelined
    drive(1'b1, 24'h000300, 3'd5, 1'b1, 1'b1);
    // R9: no lookahead past one; next-address ignored
    drive(1'b1, 24'h000400, 3'd6, 1'b0, 1'b1);
    drive(1'b0, 24'h0, 3'd0, 1'b0, 1'b0);
    // R10: plain wait
    drive(1'b1, 24'h000500, 3'd3, 1'b1, 1'b1);
    // R5: ready beats next-address
    drive(1'b1, 24'h000500, 3'd3, 1'b0, 1'b0);
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b1);
    // R6: early issue from second state
    drive(1'b1, 24'h000600, 3'd4, 1'b0, 1'b1);
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b0);
    // R6 back-to-back pipelining, then R5 close to idle
    drive(1'b1, 24'h000700, 3'd1, 1'b0, 1'b1);
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b0);
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b0);
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b1);
    // R8: idle second state closed by ready, with and without request
    drive(1'b1, 24'h000800, 3'd2, 1'b1, 1'b1);
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b1);
    drive(1'b0, 24'h0, 3'd0, 1'b0, 1'b1);
    drive(1'b1, 24'h000900, 3'd7, 1'b1, 1'b0);
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b1);
    drive(1'b0, 24'h0, 3'd0, 1'b0, 1'b1);
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b0);
    drive(1'b0, 24'h0, 3'd0, 1'b1, 1'b1);
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic v, na, rd;
      v  = ($urandom % 100) < 55;
      na = ($urandom % 100) >= 40;
      rd = ($urandom % 100) >= 35;
      drive(v, AW'($urandom), DW'($urandom), na, rd);
      if (i == 1500) doReset();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule